// File: doc/BRIEF.md
# SPI Receive Sample Delay Unit

This block moves the instant at which an SPI master captures its serial receive input. The delay is a whole number of serial clock cycles after the default capture point. The receive data pin enters a tapped shift register that advances on every serial clock edge. A tap selector then picks either the undelayed pin or one of the delayed copies and hands it to the receive shifter. This lets the master make up for the round-trip delay through the pads and the board.

The delay setting is held in one 32-bit register, reached through a small APB-style slave with zero wait states. The setting uses the low byte of that register; the upper bits always read as zero. A setting of zero selects the undelayed input. A setting larger than the depth of the shift register also falls back to zero delay. While the controller enable input is high, writes to the setting are silently dropped, so the selected tap cannot move during a transfer.

A build parameter can remove the delay feature. The register then does not exist: reads at its offset return zero, writes are ignored, and the receive pin goes straight to the output. Moving signals between clock domains is outside this block. The register slave and the delay line share one clock.

Top module: `spi_rx_skew`

## Requirements
- R1: After reset the delay setting is 0, a read at the register offset returns 0, and `rxd_smp_o` equals `rxd_i` in the same cycle.
- R2: A write at the register offset while `ctrl_en_i` is low loads `pwdata_i[7:0]` into the setting. A later read returns that value in bits 7:0, and bits 31:8 read as zero whatever was written to them.
- R3: With a setting d where 1 <= d <= DEPTH, `rxd_smp_o` in a cycle equals the value `rxd_i` held d clock cycles earlier.
- R4: With a setting of 0, `rxd_smp_o` equals `rxd_i` combinationally, with no delay.
- R5: With a setting greater than DEPTH (default 8), `rxd_smp_o` equals `rxd_i` with no delay.
- R6: A write while `ctrl_en_i` is high has no effect. The setting, its readback and the applied delay stay unchanged.
- R7: Only the offset REG_OFS (default 0x3C) is decoded. Writes at any other address are ignored, reads at any other address return 0, and `prdata_o` is 0 whenever no read is selected.
- R8: With HAS_DLY = 0, reads return 0, writes are ignored and `rxd_smp_o` always equals `rxd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock, which also clocks the register slave |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_en_i | input | 1 | Controller enable; while high, the setting is locked |
| psel_i | input | 1 | Register slave select |
| pwrite_i | input | 1 | High for a write, low for a read |
| paddr_i | input | AW | Register byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, combinational, zero wait states |
| rxd_i | input | 1 | Serial receive data from the pin |
| rxd_smp_o | output | 1 | Receive data at the selected delay, fed to the receive shifter |

## Verification
On every cycle, the assertions check four things: the reserved bits of read data stay at zero, unselected or off-offset reads return zero, the setting does not move while the controller is enabled, and the output matches a history of the receive input at the selected depth (or the undelayed input for zero and out-of-range settings). Other behaviour only shows up in the bench's scenarios. These cover the full sweep of written values with readback, decode of other addresses, the sequence of a write dropped while enabled followed by the same write accepted once disabled, and the configured-out variant working beside the full one.

// File: rtl/spi_rx_skew_pkg.sv
`timescale 1ns/1ps
package spi_rx_skew_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SET_W  = 8;
  typedef logic [SET_W-1:0]  skew_t;
  typedef logic [DATA_W-1:0] word_t;

  // nonzero and within the line depth
  function automatic logic tap_valid(skew_t s, int unsigned depth);
    return (s != '0) && (int'(s) <= int'(depth));
  endfunction
endpackage

// File: rtl/rx_skew_regs.sv
`timescale 1ns/1ps
module rx_skew_regs
  import spi_rx_skew_pkg::*;
#(
  parameter bit          HAS_DLY = 1'b1,
  parameter int unsigned AW      = 8,
  parameter logic [AW-1:0] REG_OFS = AW'('h3C)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic          psel_i,
  input  logic          pwrite_i,
  input  logic [AW-1:0] paddr_i,
  input  word_t         pwdata_i,
  output word_t         prdata_o,
  output skew_t         set_o
);
  localparam int unsigned PAD_W = DATA_W - SET_W;

  if (HAS_DLY) begin : g_reg
    logic  hit, wr_en, rd_en;
    skew_t set_q;
    logic  unused_hi;

    assign hit       = psel_i && (paddr_i == REG_OFS);
    assign wr_en     = hit && pwrite_i && !lock_i;
    assign rd_en     = hit && !pwrite_i;
    assign unused_hi = ^pwdata_i[DATA_W-1:SET_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    set_q <= '0;
      else if (wr_en) set_q <= pwdata_i[SET_W-1:0];
    end

    assign set_o    = set_q;
    assign prdata_o = rd_en ? {{PAD_W{1'b0}}, set_q} : '0;
  end else begin : g_none
    logic unused_in;
    assign unused_in = ^{clk_i, rst_ni, lock_i, psel_i, pwrite_i, paddr_i, pwdata_i};
    assign set_o     = '0;
    assign prdata_o  = '0;
  end
endmodule

// File: rtl/rx_skew_line.sv
`timescale 1ns/1ps
module rx_skew_line #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rxd_i,
  output logic [DEPTH-1:0] taps_o
);
  logic [DEPTH-1:0] sr_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[k] <= 1'b0;
        else         sr_q[k] <= rxd_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[k] <= 1'b0;
        else         sr_q[k] <= sr_q[k-1];
      end
    end
  end

  assign taps_o = sr_q;
endmodule

// File: rtl/rx_skew_tap.sv
`timescale 1ns/1ps
module rx_skew_tap
  import spi_rx_skew_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic             rxd_i,
  input  logic [DEPTH-1:0] taps_i,
  input  skew_t            set_i,
  output logic             rxd_o
);
  logic [DEPTH-1:0] sel_oh;
  logic             tap_bit;

  // one-hot decode: set value k+1 picks stage k
  for (genvar k = 0; k < DEPTH; k++) begin : g_dec
    assign sel_oh[k] = (set_i == SET_W'(k + 1));
  end

  assign tap_bit = |(sel_oh & taps_i);
  // zero or beyond depth: undelayed pin
  assign rxd_o   = tap_valid(set_i, DEPTH) ? tap_bit : rxd_i;
endmodule

// File: rtl/spi_rx_skew.sv
`timescale 1ns/1ps
module spi_rx_skew
  import spi_rx_skew_pkg::*;
#(
  parameter bit            HAS_DLY = 1'b1,
  parameter int unsigned   DEPTH   = 8,
  parameter int unsigned   AW      = 8,
  parameter logic [AW-1:0] REG_OFS = AW'('h3C)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_en_i,
  input  logic          psel_i,
  input  logic          pwrite_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [31:0]   pwdata_i,
  output logic [31:0]   prdata_o,
  input  logic          rxd_i,
  output logic          rxd_smp_o
);
  skew_t dly_set;

  rx_skew_regs #(
    .HAS_DLY (HAS_DLY),
    .AW      (AW),
    .REG_OFS (REG_OFS)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (ctrl_en_i),
    .psel_i   (psel_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .pwdata_i (pwdata_i),
    .prdata_o (prdata_o),
    .set_o    (dly_set)
  );

  if (HAS_DLY) begin : g_dly
    logic [DEPTH-1:0] taps;

    rx_skew_line #(.DEPTH(DEPTH)) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rxd_i  (rxd_i),
      .taps_o (taps)
    );

    rx_skew_tap #(.DEPTH(DEPTH)) u_tap (
      .rxd_i  (rxd_i),
      .taps_i (taps),
      .set_i  (dly_set),
      .rxd_o  (rxd_smp_o)
    );
  end else begin : g_pass
    logic unused_set;
    assign unused_set = ^dly_set;
    assign rxd_smp_o  = rxd_i;
  end
endmodule

// File: rtl/spi_rx_skew_chk.sv
`timescale 1ns/1ps
module spi_rx_skew_chk #(
  parameter bit            HAS_DLY = 1'b1,
  parameter int unsigned   DEPTH   = 8,
  parameter int unsigned   AW      = 8,
  parameter logic [AW-1:0] REG_OFS = AW'('h3C)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ctrl_en_i,
  input logic          psel_i,
  input logic          pwrite_i,
  input logic [AW-1:0] paddr_i,
  input logic [31:0]   prdata_o,
  input logic          rxd_i,
  input logic          rxd_smp_o,
  input logic [7:0]    set_i
);
  logic [DEPTH-1:0] hist_q;
  logic             hist_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[DEPTH-2:0], rxd_i};
  end

  always_comb begin
    hist_bit = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      if (int'(set_i) == k + 1) hist_bit = hist_q[k];
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prdata_o[31:8] == 24'h0);

  assert_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psel_i || pwrite_i || paddr_i != REG_OFS) |-> prdata_o == 32'h0);

  assert_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_en_i |=> $stable(set_i));

  assert_zero_dly_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i == 8'd0 |-> rxd_smp_o == rxd_i);

  assert_oob_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(set_i) > int'(DEPTH) |-> rxd_smp_o == rxd_i);

  assert_tap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != 8'd0 && int'(set_i) <= int'(DEPTH)) |-> rxd_smp_o == hist_bit);

  if (!HAS_DLY) begin : g_off
    assert_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prdata_o == 32'h0 && rxd_smp_o == rxd_i);
  end
endmodule

bind spi_rx_skew spi_rx_skew_chk #(
  .HAS_DLY (HAS_DLY),
  .DEPTH   (DEPTH),
  .AW      (AW),
  .REG_OFS (REG_OFS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_en_i (ctrl_en_i),
  .psel_i    (psel_i),
  .pwrite_i  (pwrite_i),
  .paddr_i   (paddr_i),
  .prdata_o  (prdata_o),
  .rxd_i     (rxd_i),
  .rxd_smp_o (rxd_smp_o),
  .set_i     (dly_set)
);

// File: tb/spi_rx_skew_test.sv
`timescale 1ns/1ps
module spi_rx_skew_test;
  localparam int unsigned   DEPTH = 8;
  localparam logic [7:0]    OFS   = 8'h3C;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_en_i = 1'b0;
  logic        psel_i = 1'b0;
  logic        pwrite_i = 1'b0;
  logic [7:0]  paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [31:0] prdata_o, prdata_off;
  logic        rxd_i = 1'b0;
  logic        rxd_smp_o, rxd_off;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  spi_rx_skew #(.HAS_DLY(1'b1), .DEPTH(DEPTH), .AW(8), .REG_OFS(OFS)) uut (
    .clk_i, .rst_ni, .ctrl_en_i, .psel_i, .pwrite_i, .paddr_i, .pwdata_i,
    .prdata_o, .rxd_i, .rxd_smp_o
  );

  spi_rx_skew #(.HAS_DLY(1'b0), .DEPTH(DEPTH), .AW(8), .REG_OFS(OFS)) uut_off (
    .clk_i, .rst_ni, .ctrl_en_i, .psel_i, .pwrite_i, .paddr_i, .pwdata_i,
    .prdata_o (prdata_off), .rxd_i, .rxd_smp_o (rxd_off)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b1; paddr_i = a; pwdata_i = d;
    @(negedge clk_i);
    psel_i = 1'b0; pwrite_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] v, output logic [31:0] v_off);
    @(negedge clk_i);
    psel_i = 1'b1; pwrite_i = 1'b0; paddr_i = a;
    #1;
    v = prdata_o; v_off = prdata_off;
    psel_i = 1'b0;
  endtask

  // drive a pseudo-random bit stream; expect the output lagged by exp_d cycles
  task automatic run_stream(input int exp_d, input logic [6:0] seed, input bit try_wr, input string req);
    logic [6:0] lfsr = seed;
    logic       drv [0:47];
    for (int k = 0; k < 48; k++) begin
      @(negedge clk_i);
      lfsr   = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      drv[k] = lfsr[0];
      rxd_i  = drv[k];
      if (try_wr && k == 20) begin
        psel_i = 1'b1; pwrite_i = 1'b1; paddr_i = OFS; pwdata_i = 32'h0000_0003;
      end else begin
        psel_i = 1'b0; pwrite_i = 1'b0;
      end
      #1;
      if (k >= DEPTH + 1)
        check(rxd_smp_o === drv[k - exp_d], req, rxd_smp_o, drv[k - exp_d]);
      if (k == 30)
        check(rxd_off === rxd_i, "R8", rxd_off, rxd_i);
    end
    @(negedge clk_i);
    psel_i = 1'b0; pwrite_i = 1'b0;
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rv, rv_off;
    int d_list [14] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 12, 128, 255};

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    reg_rd(OFS, rv, rv_off);
    check(rv == 32'h0, "R1", rv, 0);
    @(negedge clk_i); rxd_i = 1'b1; #1;
    check(rxd_smp_o === 1'b1, "R1", rxd_smp_o, 1);
    @(negedge clk_i); rxd_i = 1'b0; #1;
    check(rxd_smp_o === 1'b0, "R1", rxd_smp_o, 0);

    // R2: every value, reserved bits driven high-ish
    for (int v = 0; v < 256; v++) begin
      reg_wr(OFS, {24'hA5C35A, 8'(v)});
      reg_rd(OFS, rv, rv_off);
      check(rv == 32'(v), "R2", rv, v);
      if (v % 64 == 0) check(rv_off == 32'h0, "R8", rv_off, 0);
    end

    // R7: decode of other addresses
    reg_wr(OFS, 32'h5);
    reg_wr(OFS + 8'h4, 32'h7);
    reg_wr(8'h00, 32'h9);
    reg_rd(OFS, rv, rv_off);
    check(rv == 32'h5, "R7", rv, 5);
    reg_rd(OFS + 8'h4, rv, rv_off);
    check(rv == 32'h0, "R7", rv, 0);
    @(negedge clk_i); paddr_i = OFS; pwrite_i = 1'b0; psel_i = 1'b0; #1;
    check(prdata_o == 32'h0, "R7", prdata_o, 0);
    @(negedge clk_i); psel_i = 1'b1; pwrite_i = 1'b1; #1;
    check(prdata_o == 32'h0, "R7", prdata_o, 0);
    @(negedge clk_i); psel_i = 1'b0; pwrite_i = 1'b0;

    // R3/R4/R5: delay sweep, controller enabled during each stream
    foreach (d_list[i]) begin
      int    d = d_list[i];
      int    e = (d >= 1 && d <= DEPTH) ? d : 0;
      string r = (d == 0) ? "R4" : (d <= DEPTH ? "R3" : "R5");
      reg_wr(OFS, 32'(d));
      @(negedge clk_i); ctrl_en_i = 1'b1;
      run_stream(e, 7'(i * 9 + 1), (i % 3 == 1), r);
      @(negedge clk_i); ctrl_en_i = 1'b0;
    end

    // R6: write while enabled is dropped, later accepted once disabled
    reg_wr(OFS, 32'h4);
    @(negedge clk_i); ctrl_en_i = 1'b1;
    reg_wr(OFS, 32'h2);
    reg_rd(OFS, rv, rv_off);
    check(rv == 32'h4, "R6", rv, 4);
    run_stream(4, 7'h2B, 1'b1, "R6");
    reg_rd(OFS, rv, rv_off);
    check(rv == 32'h4, "R6", rv, 4);
    @(negedge clk_i); ctrl_en_i = 1'b0;
    reg_wr(OFS, 32'h2);
    reg_rd(OFS, rv, rv_off);
    check(rv == 32'h2, "R6", rv, 2);
    run_stream(2, 7'h51, 1'b0, "R3");

    // R8: configured-out variant after writes
    reg_rd(OFS, rv, rv_off);
    check(rv_off == 32'h0, "R8", rv_off, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule